// File: doc/BRIEF.md
# Free-Running Timer with Input Capture and Output Compare

The block is a 16-bit up-counter that advances on a prescaled version of the system clock or on rising edges of an external clock pin. One compare register is checked against the counter. When they are equal on a count step, the block raises a compare flag. It can also send the counter back to zero, which gives a programmable period.

Four capture channels watch their input pins through two synchronizing flops. On the selected edge, a channel copies the counter into its capture register and raises its capture flag. Channels A and B can be chained to C and D as backing registers, so the last two readings of A or B are kept.

Software reaches every register over a simple synchronous bus. Writes take effect on the clock edge. Reads are combinational from the addressed register. Flags are cleared by reading them as 1 and then writing 0 to them.

Top module: `frt_capcmp`

## Requirements
- R1: The control register (address 6) reads 0x00 after reset and returns to 0x00 in the cycle after `standby` is high. Standby takes priority over a bus write. All eight of its bits read back what was written.
- R2: Control field layout: bits 7, 6, 5 and 4 are the edge selects of channels A, B, C and D. Bits 3 and 2 are the buffer enables of A and B. Bits 1:0 are the counter clock select.
- R3: A channel's edge select of 0 captures on a falling pin edge, and 1 captures on a rising edge. The opposite edge captures nothing. Each channel follows only its own bit.
- R4: A capture copies the counter into that channel's capture register (addresses 2 to 5 for A to D, reset 0x0000). It also sets that channel's flag, status bits 0 to 3 for A to D. The new value is readable after the third clock edge following the pin change.
- R5: With buffer A enabled, a channel-A capture moves the old capture A value into capture C and loads the count into A. The pin of channel C then neither captures nor sets flag C. Buffer B works the same way on B and D.
- R6: Clock select 00, 01 and 10 advance the counter once every 2, 8 and 32 clocks. Clock select 11 advances it once per rising edge of `ext_clk`, seen through two synchronizing flops.
- R7: With status bit 7 (clear enable) set, a count step taken while the counter equals the compare register (address 1, reset 0xFFFF) loads zero. With the bit clear, the counter keeps counting.
- R8: A count step taken while the counter equals the compare register sets the compare flag, status bit 4.
- R9: A count step from 0xFFFF that is not a compare clear gives 0x0000 and sets the overflow flag, status bit 5.
- R10: Writing 0 to a flag bit of the status register (address 7) clears it only if an earlier status read returned that bit as 1. Writing 1 leaves a flag unchanged. A flag set by hardware in the same cycle stays set.
- R11: A bus write to the counter (address 0) takes priority over a count step in the same cycle. It also suppresses that cycle's compare clear, compare flag and overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Standby request; clears the control register |
| ext_clk | input | 1 | External counter clock, asynchronous |
| cap_pin | input | 4 | Capture inputs, bit 0 is channel A, asynchronous |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |

## Verification
On every cycle, the assertions check the following behaviour:
- The counter holds still between count steps.
- A counter write lands the written value.
- A wrap from 0xFFFF gives zero and sets the overflow flag.
- A compare clear gives zero, and a match on a count step raises the compare flag.
- Capture C stays frozen in buffer mode unless channel A captures.
- Standby clears the control register.
- Flags never drop without a status write.

The bench scenarios show what depends on pin sequences and exact counts:
- Edge polarity per channel.
- The captured values and the buffer chaining.
- The exact number of steps for each prescaler setting.
- The read-then-write flag clearing rule.
- The collision in which a counter write wins over a compare clear.

// File: rtl/frt_pkg.sv
`timescale 1ns/1ps
// Shared definitions of the free-running timer: register addresses,
// clock-select codes and status bit positions.
package frt_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CNT  = 4'd0,
        A_OCR  = 4'd1,
        A_CAPA = 4'd2,
        A_CAPB = 4'd3,
        A_CAPC = 4'd4,
        A_CAPD = 4'd5,
        A_CTRL = 4'd6,
        A_STAT = 4'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        CK_DIV2  = 2'b00,
        CK_DIV8  = 2'b01,
        CK_DIV32 = 2'b10,
        CK_EXT   = 2'b11
    } clk_sel_e;

    localparam int N_CAP  = 4;
    localparam int F_CMP  = 4;
    localparam int F_OVF  = 5;
    localparam int N_FLAG = 6;
endpackage

// File: rtl/frt_prescaler.sv
`timescale 1ns/1ps
// Count-step generator. Produces a one-cycle tick at 1/2, 1/8 or 1/32 of
// the clock, or once per synchronized rising edge of the external clock.
// Assumes ext_clk is slow compared to clk (high and low for at least 2 clocks).
module frt_prescaler
    import frt_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clk_sel_e sel,
    input  logic     ext_clk,
    output logic     tick
);
    localparam int SH_A  = 1;
    localparam int SH_B  = 3;
    localparam int SH_C  = 5;
    localparam int DIV_W = SH_C;

    logic [DIV_W-1:0] div_q;
    logic [SYNC:0]    ext_sr;
    logic             ext_rise;

    // Free-running divider, shared by the three internal rates.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Synchronizer for the external clock, plus one stage of history.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sr <= '0;
        else        ext_sr <= {ext_sr[SYNC-1:0], ext_clk};
    end

    assign ext_rise = ext_sr[SYNC-1] & ~ext_sr[SYNC];

    // Tick selection from the divider phase or the external edge.
    always_comb begin
        unique case (sel)
            CK_DIV2:  tick = &div_q[SH_A-1:0];
            CK_DIV8:  tick = &div_q[SH_B-1:0];
            CK_DIV32: tick = &div_q[SH_C-1:0];
            default:  tick = ext_rise;
        endcase
    end
endmodule

// File: rtl/frt_edge_det.sv
`timescale 1ns/1ps
// Capture pin front end: synchronizes an asynchronous pin and flags the
// selected edge for one cycle. rise_sel = 1 selects rising, 0 falling.
// Assumes pins reset low; a pin held high at reset can report one rising edge.
module frt_edge_det #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic evt
);
    logic [SYNC:0] sr;

    // Synchronizer chain with one extra stage for edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[SYNC-1:0], pin};
    end

    assign evt = rise_sel ? (sr[SYNC-1] & ~sr[SYNC]) : (~sr[SYNC-1] & sr[SYNC]);
endmodule

// File: rtl/frt_capcmp.sv
`timescale 1ns/1ps
// Free-running timer top: counter, compare A with optional clear, four
// capture channels with A->C and B->D buffering, flags and register bus.
// Assumes one bus access per cycle; reads are combinational, writes on edge.
module frt_capcmp
    import frt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SYNC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              ext_clk,
    input  logic [N_CAP-1:0]  cap_pin,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata
);
    localparam int CTRL_W = 8;
    localparam int STAT_W = 8;

    logic [CNT_W-1:0]  cnt_q, ocr_q;
    logic [CNT_W-1:0]  cap_q [N_CAP];
    logic [CTRL_W-1:0] ctrl_q;
    logic [N_FLAG-1:0] flag_q, armed_q, flag_set, flag_clr;
    logic              clr_en_q;
    logic              tick, match, cmp_evt, clr_evt, ovf_evt;
    logic              cnt_wr, ocr_wr, ctrl_wr, stat_wr, stat_rd;
    logic              buf_a, buf_b;
    logic [N_CAP-1:0]  cap_evt, cap_take;

    assign cnt_wr  = bus_sel & bus_wr  & (bus_addr == A_CNT);
    assign ocr_wr  = bus_sel & bus_wr  & (bus_addr == A_OCR);
    assign ctrl_wr = bus_sel & bus_wr  & (bus_addr == A_CTRL);
    assign stat_wr = bus_sel & bus_wr  & (bus_addr == A_STAT);
    assign stat_rd = bus_sel & ~bus_wr & (bus_addr == A_STAT);
    assign buf_a   = ctrl_q[3];
    assign buf_b   = ctrl_q[2];

    frt_prescaler #(.SYNC(SYNC)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(clk_sel_e'(ctrl_q[1:0])),
        .ext_clk(ext_clk), .tick(tick)
    );

    // One edge detector per capture pin; channel i uses control bit 7-i.
    for (genvar i = 0; i < N_CAP; i++) begin : g_cap
        frt_edge_det #(.SYNC(SYNC)) u_edge (
            .clk(clk), .rst_n(rst_n), .pin(cap_pin[i]),
            .rise_sel(ctrl_q[CTRL_W-1-i]), .evt(cap_evt[i])
        );
    end

    // Backing channels lose their own pin while buffering.
    assign cap_take = {cap_evt[3] & ~buf_b, cap_evt[2] & ~buf_a, cap_evt[1:0]};

    assign match   = (cnt_q == ocr_q);
    assign cmp_evt = tick & match & ~cnt_wr;
    assign clr_evt = cmp_evt & clr_en_q;
    assign ovf_evt = tick & (&cnt_q) & ~clr_evt & ~cnt_wr;

    // Counter: bus write first, then count step with optional compare clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_wr)  cnt_q <= bus_wdata;
        else if (clr_evt) cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + 1'b1;
    end

    // Compare register, reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)      ocr_q <= '1;
        else if (ocr_wr) ocr_q <= bus_wdata;
    end

    // Control register, cleared by reset and by standby.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) ctrl_q <= '0;
        else if (ctrl_wr)      ctrl_q <= bus_wdata[CTRL_W-1:0];
    end

    // Capture registers with the A->C and B->D buffer moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CAP; i++) cap_q[i] <= '0;
        end else begin
            if (cap_take[0]) cap_q[0] <= cnt_q;
            if (cap_take[1]) cap_q[1] <= cnt_q;
            if (buf_a && cap_evt[0]) cap_q[2] <= cap_q[0];
            else if (cap_take[2])    cap_q[2] <= cnt_q;
            if (buf_b && cap_evt[1]) cap_q[3] <= cap_q[1];
            else if (cap_take[3])    cap_q[3] <= cnt_q;
        end
    end

    assign flag_set = {ovf_evt, cmp_evt, cap_take};
    assign flag_clr = stat_wr ? (armed_q & ~bus_wdata[N_FLAG-1:0]) : '0;

    // Flags: hardware set wins over a software clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | flag_set;
    end

    // Read-as-1 memory that arms the clear; every status write disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= '0;
        else if (stat_rd) armed_q <= armed_q | flag_q;
        else if (stat_wr) armed_q <= '0;
    end

    // Clear-on-compare enable, kept in status bit 7.
    always_ff @(posedge clk) begin
        if (!rst_n)       clr_en_q <= 1'b0;
        else if (stat_wr) clr_en_q <= bus_wdata[STAT_W-1];
    end

    // Combinational read multiplexer.
    always_comb begin
        case (bus_addr)
            A_CNT:   bus_rdata = cnt_q;
            A_OCR:   bus_rdata = ocr_q;
            A_CAPA:  bus_rdata = cap_q[0];
            A_CAPB:  bus_rdata = cap_q[1];
            A_CAPC:  bus_rdata = cap_q[2];
            A_CAPD:  bus_rdata = cap_q[3];
            A_CTRL:  bus_rdata = CNT_W'(ctrl_q);
            A_STAT:  bus_rdata = CNT_W'({clr_en_q, 1'b0, flag_q});
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/frt_capcmp_chk.sv
`timescale 1ns/1ps
// Property checker for frt_capcmp, bound to every instance of the top.
module frt_capcmp_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             standby,
    input logic             tick,
    input logic             cnt_wr,
    input logic             stat_wr,
    input logic [CNT_W-1:0] wdata,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] ocr,
    input logic             clr_en,
    input logic [7:0]       ctrl,
    input logic [5:0]       flags,
    input logic             evt_a,
    input logic [CNT_W-1:0] cap_c
);
    p_standby_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (ctrl == 8'h00));

    p_hold_between_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !tick) |=> $stable(cnt));

    p_compare_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && clr_en && cnt == ocr) |=> (cnt == '0));

    p_compare_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt == ocr) |=> flags[4]);

    p_wrap_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && (&cnt) && !(clr_en && cnt == ocr)) |=> (cnt == '0 && flags[5]));

    p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((flags & $past(flags)) == $past(flags)));

    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wdata)));

    p_buffer_c_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[3] && !evt_a) |=> $stable(cap_c));
endmodule

bind frt_capcmp frt_capcmp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .standby(standby), .tick(tick),
    .cnt_wr(cnt_wr), .stat_wr(stat_wr), .wdata(bus_wdata), .cnt(cnt_q),
    .ocr(ocr_q), .clr_en(clr_en_q), .ctrl(ctrl_q), .flags(flag_q),
    .evt_a(cap_evt[0]), .cap_c(cap_q[2])
);

// File: tb/tb_frt_capcmp.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expectations, a monitor compares them.
module tb_frt_capcmp;
    import frt_pkg::*;

    typedef struct {
        logic [15:0] lo;
        logic [15:0] hi;
        string       tag;
    } exp_t;

    logic        clk = 0, rst_n = 0, standby = 0, ext_clk = 0;
    logic [3:0]  cap_pin = '0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    exp_t        sb[$];
    int          n_chk = 0, n_err = 0;
    bit          done = 0;

    frt_capcmp dut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .ext_clk(ext_clk),
        .cap_pin(cap_pin), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #2ns clk = ~clk;

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1ns;
    endtask

    task automatic wr(input reg_addr_e a, input logic [15:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1ns;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input reg_addr_e a, input logic [15:0] lo,
                      input logic [15:0] hi, input string tag);
        exp_t e;
        e.lo = lo; e.hi = hi; e.tag = tag;
        sb.push_back(e);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(posedge clk); #1ns;
        bus_sel = 0;
    endtask

    // Monitor: pops one expectation per read and compares at the falling edge.
    always @(negedge clk) begin
        if (bus_sel && !bus_wr && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (bus_rdata < e.lo || bus_rdata > e.hi) begin
                n_err++;
                $display("FAIL %s: got %h expected %h..%h", e.tag, bus_rdata, e.lo, e.hi);
            end
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        rd(A_CTRL, 16'h0000, 16'h0000, "R1 control after reset");
        rd(A_STAT, 16'h0000, 16'h0000, "R10 status after reset");
        rd(A_OCR,  16'hFFFF, 16'hFFFF, "R7 compare reset value");
        wr(A_CTRL, 16'h00FF);
        rd(A_CTRL, 16'h00FF, 16'h00FF, "R1 control read back");
        standby = 1; wr(A_CTRL, 16'h0055); standby = 0;
        rd(A_CTRL, 16'h0000, 16'h0000, "R1 standby clears control");

        // R2 R3 R4: A rising, B falling, C rising, D falling, external clock.
        wr(A_CTRL, 16'h00A3);
        wr(A_CNT, 16'h1234);
        cap_pin = 4'hF; idle(3);
        rd(A_CAPA, 16'h1234, 16'h1234, "R4 capture A on rising");
        rd(A_CAPB, 16'h0000, 16'h0000, "R3 B ignores rising edge");
        rd(A_CAPC, 16'h1234, 16'h1234, "R3 C captures rising");
        rd(A_CAPD, 16'h0000, 16'h0000, "R3 D ignores rising edge");
        rd(A_STAT, 16'h0005, 16'h0005, "R4 flags A and C");
        for (int k = 0; k < 3; k++) begin
            ext_clk = 1; idle(2); ext_clk = 0; idle(2);
        end
        idle(1);
        rd(A_CNT, 16'h1237, 16'h1237, "R6 external clock steps");
        cap_pin = 4'h0; idle(3);
        rd(A_CAPB, 16'h1237, 16'h1237, "R3 B captures falling");
        rd(A_CAPD, 16'h1237, 16'h1237, "R3 D captures falling");
        rd(A_CAPA, 16'h1234, 16'h1234, "R3 A ignores falling");

        // R10: only flags read as 1 are cleared; writing 1 keeps a flag.
        wr(A_STAT, 16'h0000);
        rd(A_STAT, 16'h000A, 16'h000A, "R10 unread flags survive");
        wr(A_STAT, 16'h0002);
        rd(A_STAT, 16'h0002, 16'h0002, "R10 writing 1 keeps flag");
        wr(A_STAT, 16'h0000);
        rd(A_STAT, 16'h0000, 16'h0000, "R10 all flags cleared");

        // R5: buffer A chains old capture A into C; C pin ignored.
        wr(A_CTRL, 16'h008B);
        wr(A_CNT, 16'h0100);
        cap_pin[0] = 1; idle(3);
        rd(A_CAPA, 16'h0100, 16'h0100, "R5 buffer A new value");
        rd(A_CAPC, 16'h1234, 16'h1234, "R5 old A moved to C");
        cap_pin[0] = 0; idle(3);
        wr(A_CNT, 16'h0200);
        cap_pin[0] = 1; idle(3);
        rd(A_CAPA, 16'h0200, 16'h0200, "R5 buffer A second value");
        rd(A_CAPC, 16'h0100, 16'h0100, "R5 C holds previous A");
        cap_pin[2] = 1; idle(3); cap_pin[2] = 0; idle(3);
        rd(A_CAPC, 16'h0100, 16'h0100, "R5 C pin ignored");
        rd(A_STAT, 16'h0001, 16'h0001, "R5 no flag C in buffer mode");
        wr(A_STAT, 16'h0000);
        wr(A_CTRL, 16'h0047);
        wr(A_CNT, 16'h0300);
        cap_pin[1] = 1; idle(3);
        rd(A_CAPB, 16'h0300, 16'h0300, "R5 buffer B new value");
        rd(A_CAPD, 16'h1237, 16'h1237, "R5 old B moved to D");

        // R6: internal prescaler rates over 64 clocks.
        wr(A_CTRL, 16'h0000); wr(A_CNT, 16'h0000); idle(64);
        rd(A_CNT, 16'h0020, 16'h0020, "R6 divide by 2");
        wr(A_CTRL, 16'h0001); wr(A_CNT, 16'h0000); idle(64);
        rd(A_CNT, 16'h0008, 16'h0008, "R6 divide by 8");
        wr(A_CTRL, 16'h0002); wr(A_CNT, 16'h0000); idle(64);
        rd(A_CNT, 16'h0002, 16'h0002, "R6 divide by 32");

        // R7 R8: clear on compare, period of 6 steps.
        wr(A_CTRL, 16'h0000);
        rd(A_STAT, 16'h0000, 16'h00FF, "R10 arm before clear");
        wr(A_OCR, 16'h0005);
        wr(A_STAT, 16'h0080);
        wr(A_CNT, 16'h0000); idle(40);
        rd(A_CNT, 16'h0002, 16'h0002, "R7 counter cleared at compare");
        rd(A_STAT, 16'h0090, 16'h0090, "R8 compare flag set");
        wr(A_STAT, 16'h0000);
        wr(A_CNT, 16'h0000); idle(40);
        rd(A_CNT, 16'h0014, 16'h0014, "R7 free running without clear");
        rd(A_STAT, 16'h0010, 16'h0010, "R8 compare flag while free");

        // R9: wrap from 0xFFFF.
        wr(A_STAT, 16'h0000);
        wr(A_OCR, 16'h8000);
        wr(A_CNT, 16'hFFFC); idle(20);
        rd(A_CNT, 16'h0006, 16'h0006, "R9 counter wrapped");
        rd(A_STAT, 16'h0020, 16'h0020, "R9 overflow flag");

        // R11: counter write collides with a compare-clear step.
        wr(A_CTRL, 16'h0003);
        wr(A_OCR, 16'h0050);
        wr(A_STAT, 16'h0080);
        wr(A_CNT, 16'h0050);
        ext_clk = 1; idle(2);
        wr(A_CNT, 16'h0AAA);
        rd(A_CNT, 16'h0AAA, 16'h0AAA, "R11 write beats compare clear");
        rd(A_STAT, 16'h0080, 16'h0080, "R11 no compare flag on write");
        ext_clk = 0;
        idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule